// File: doc/BRIEF.md
# Scaled-Line Pixel Address Generator

This block drives the addressing side of a blitter that copies one line of a sprite while enlarging or shrinking it. The host loads a source start address, a destination start address, the number of destination pixels to write, an integer base stride N and a reduced length R for the error stage, then pulses `start`. From the next cycle on the block emits one source/destination address pair per clock, marked by `pix_valid`, until every destination pixel is covered. It then pulses `done` and holds its last pair.

The destination address steps by one on every pixel. The source address steps by N or N+1, chosen by an incremental error term of the kind used in line drawing. With N = 0 the block stretches (source steps of 0 or 1). With N = floor((S-1)/(D-1)) and R = ((S-1) mod (D-1)) + 1 it squashes S source pixels into D destination pixels and skips source pixels instead of visiting each one. The host computes N and R; the block only computes the error constants from D and R when a line starts. Both possible error sums are formed side by side each cycle and one is selected, so the error path holds one adder, not two in series.

Top module: `bscale_addr_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `pix_valid` and `done` are 0 and `src_addr`, `dst_addr` are 0.
- R2: A `start` sampled while idle makes the first pair valid in the next cycle, with `src_addr` equal to `src_base` and `dst_addr` equal to `dst_base`.
- R3: On each valid cycle after the first, `dst_addr` is the previous `dst_addr` plus 1.
- R4: With dx = count-1 and dy = R-1, an error e starts at 2*dy-dx. On each step, if e >= 0 the source advances by N+1 and e gains 2*dy-2*dx; otherwise it advances by N and e gains 2*dy. So (N=0, R=2, count 4) yields source offsets 0,0,1,1 and (N=5, R=2, count 4) yields 0,5,11,16.
- R5: `pix_valid` and `busy` are high for exactly `pix_count` consecutive cycles per line.
- R6: `done` is high for exactly one cycle, the cycle right after the last valid pair, and `busy` is low in that cycle.
- R7: A `start` sampled while `busy` is high has no effect: the running line keeps its addresses, stride and length, even if the base, count, stride and length inputs change.
- R8: After the last pair, with no new start, `src_addr` and `dst_addr` hold the last emitted pair. A count of 1 emits one pair at the base addresses.
- R9: Both addresses are 16 bits and wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a line (taken only while idle) |
| src_base | input | 16 | First source address |
| dst_base | input | 16 | First destination address |
| pix_count | input | 11 | Destination pixel count, 1 to 1024 |
| skip | input | 16 | Base source stride N |
| frac_len | input | 11 | Reduced source length R for the error stage, 1 to pix_count |
| busy | output | 1 | Line in progress |
| pix_valid | output | 1 | Address pair valid this cycle |
| src_addr | output | 16 | Source pixel address |
| dst_addr | output | 16 | Destination pixel address |
| done | output | 1 | One-cycle pulse after the last pair |

## Verification
The assertions assume that every accepted start carries a count from 1 to 1024 and a reduced length from 1 to that count, so that twice the span fits the 12-bit signed error register and the counter never loads zero. The stimulus picks counts and lengths only inside these ranges, both in the random runs and in the directed cases (the two reference lines, a single pixel, and full-length lines at the top of the range). It picks random bases, including ones close to the top of the address space. It raises `start` with out-of-range garbage only while a line is busy, where that start must be ignored.

// File: rtl/bscale_pkg.sv
package bscale_pkg;

    localparam int ADDR_W = 16;
    localparam int ERR_W  = 12;
    localparam int CNT_W  = ERR_W - 1;

    typedef logic        [ADDR_W-1:0] addr_t;
    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic        [CNT_W-1:0]  cnt_t;

    // Constants for one line, fixed from start to done
    typedef struct packed {
        addr_t stride;   // base source stride N
        err_t  inc_lo;   // error gain when no source carry: 2*dy
        err_t  inc_hi;   // error gain on a carry: 2*dy - 2*dx
    } step_cfg_t;

    typedef struct packed {
        addr_t src;
        addr_t dst;
    } addr_pair_t;

    function automatic err_t widen(cnt_t v);
        return err_t'({1'b0, v});
    endfunction

    function automatic err_t span_of(cnt_t v);
        return widen(v) - err_t'(1);
    endfunction

    function automatic step_cfg_t make_cfg(cnt_t count, cnt_t frac, addr_t stride);
        step_cfg_t c;
        err_t      dx;
        err_t      dy;
        dx       = span_of(count);
        dy       = span_of(frac);
        c.stride = stride;
        c.inc_lo = dy + dy;
        c.inc_hi = (dy - dx) + (dy - dx);
        return c;
    endfunction

    function automatic err_t seed_err(cnt_t count, cnt_t frac);
        err_t dx;
        err_t dy;
        dx = span_of(count);
        dy = span_of(frac);
        return (dy + dy) - dx;
    endfunction

endpackage

// File: rtl/bscale_setup.sv
module bscale_setup
    import bscale_pkg::*;
(
    input  cnt_t      count,
    input  cnt_t      frac,
    input  addr_t     stride,
    output step_cfg_t cfg,
    output err_t      err_init
);

    // Combined constant (A+C) formed once at setup, not in the step path
    always_comb begin
        cfg      = make_cfg(count, frac, stride);
        err_init = seed_err(count, frac);
    end

endmodule

// File: rtl/bscale_err_step.sv
module bscale_err_step
    import bscale_pkg::*;
(
    input  err_t      err_q,
    input  step_cfg_t cfg,
    output err_t      err_next,
    output logic      carry
);

    err_t sum_lo;
    err_t sum_hi;

    // Both candidate sums side by side; the sign picks one
    always_comb begin
        sum_lo   = err_q + cfg.inc_lo;
        sum_hi   = err_q + cfg.inc_hi;
        carry    = ~err_q[ERR_W-1];
        err_next = carry ? sum_hi : sum_lo;
    end

endmodule

// File: rtl/bscale_addr_step.sv
module bscale_addr_step
    import bscale_pkg::*;
(
    input  addr_pair_t cur,
    input  addr_t      stride,
    input  logic       carry,
    output addr_pair_t nxt
);

    always_comb begin
        nxt.src = cur.src + stride + addr_t'(carry);
        nxt.dst = cur.dst + addr_t'(1);
    end

endmodule

// File: rtl/bscale_len_ctr.sv
module bscale_len_ctr
    import bscale_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t count,
    output logic busy,
    output logic last
);

    cnt_t left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= count;
        end else if (left_q != '0) begin
            left_q <= left_q - cnt_t'(1);
        end
    end

    assign busy = (left_q != '0);
    assign last = (left_q == cnt_t'(1));

    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);  // R5

    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        (last && !load) |=> !busy);  // R5

endmodule

// File: rtl/bscale_addr_gen.sv
module bscale_addr_gen
    import bscale_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  pix_count,
    input  logic [ADDR_W-1:0] skip,
    input  logic [CNT_W-1:0]  frac_len,
    output logic              busy,
    output logic              pix_valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              done
);

    step_cfg_t  cfg_d;
    step_cfg_t  cfg_q;
    err_t       err_init;
    err_t       err_q;
    err_t       err_next;
    logic       carry;
    addr_pair_t pair_q;
    addr_pair_t pair_next;
    logic       accept;
    logic       last;
    logic       done_q;

    assign accept = start && !busy;

    bscale_setup u_setup (
        .count    (pix_count),
        .frac     (frac_len),
        .stride   (skip),
        .cfg      (cfg_d),
        .err_init (err_init)
    );

    bscale_err_step u_err (
        .err_q    (err_q),
        .cfg      (cfg_q),
        .err_next (err_next),
        .carry    (carry)
    );

    bscale_addr_step u_addr (
        .cur    (pair_q),
        .stride (cfg_q.stride),
        .carry  (carry),
        .nxt    (pair_next)
    );

    bscale_len_ctr u_len (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .count (pix_count),
        .busy  (busy),
        .last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            err_q  <= '0;
            pair_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= busy && last;
            if (accept) begin
                cfg_q      <= cfg_d;
                err_q      <= err_init;
                pair_q.src <= src_base;
                pair_q.dst <= dst_base;
            end else if (busy && !last) begin
                err_q  <= err_next;
                pair_q <= pair_next;
            end
        end
    end

    assign pix_valid = busy;
    assign src_addr  = pair_q.src;
    assign dst_addr  = pair_q.dst;
    assign done      = done_q;

    AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |-> (dst_addr == addr_t'($past(dst_addr) + addr_t'(1))));  // R3

    AST_SRC_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |->
            ((addr_t'(src_addr - $past(src_addr)) == cfg_q.stride) ||
             (addr_t'(src_addr - $past(src_addr)) == addr_t'(cfg_q.stride + addr_t'(1)))));  // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R6

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && !pix_valid));  // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !last && start) |=> (busy && $stable(cfg_q)));  // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr)));  // R8

    AST_FIRST_PAIR: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (pix_valid && src_addr == $past(src_base) && dst_addr == $past(dst_base)));  // R2

endmodule

// File: tb/bscale_addr_gen_bench.sv
`timescale 1ns/1ps
module bscale_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] src_base = '0;
    logic [15:0] dst_base = '0;
    logic [10:0] pix_count = '0;
    logic [15:0] skip = '0;
    logic [10:0] frac_len = '0;
    logic        busy;
    logic        pix_valid;
    logic [15:0] src_addr;
    logic [15:0] dst_addr;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bscale_addr_gen u_bscale_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .pix_count (pix_count),
        .skip      (skip),
        .frac_len  (frac_len),
        .busy      (busy),
        .pix_valid (pix_valid),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .done      (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench model of the stepping rule (R4) for one source offset list
    function automatic logic [15:0] model_src(input logic [15:0] sb, input int cnt,
                                              input int n, input int r, input int idx);
        int          dx = cnt - 1;
        int          dy = r - 1;
        int          e  = 2 * dy - dx;
        logic [15:0] s  = sb;
        for (int k = 0; k < idx; k++) begin
            if (e >= 0) begin
                s = s + 16'(n + 1);
                e = e + 2 * dy - 2 * dx;
            end else begin
                s = s + 16'(n);
                e = e + 2 * dy;
            end
        end
        return s;
    endfunction

    task automatic run_line(input logic [15:0] sb, input logic [15:0] db, input int cnt,
                            input int n, input int r, input bit poke);
        logic [15:0] last_s;
        logic [15:0] last_d;
        logic [15:0] exp_s;
        src_base  = sb;
        dst_base  = db;
        pix_count = 11'(cnt);
        skip      = 16'(n);
        frac_len  = 11'(r);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        last_s = sb;
        last_d = db;
        for (int i = 0; i < cnt; i++) begin
            exp_s = model_src(sb, cnt, n, r, i);
            if (i == 0) begin
                chk("R2 first src", 32'(src_addr), 32'(sb));
                chk("R2 first dst", 32'(dst_addr), 32'(db));
            end else begin
                chk("R3 R9 dst step", 32'(dst_addr), 32'(16'(db + 16'(i))));
                chk("R4 R7 R9 src step", 32'(src_addr), 32'(exp_s));
            end
            chk("R5 valid in run", 32'(pix_valid), 32'd1);
            chk("R6 done low in run", 32'(done), 32'd0);
            last_s = exp_s;
            last_d = 16'(db + 16'(i));
            if (poke && (i % 3 == 1)) begin
                start     = 1'b1;
                src_base  = 16'($urandom);
                dst_base  = 16'($urandom);
                pix_count = 11'($urandom);
                skip      = 16'($urandom);
                frac_len  = 11'($urandom);
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk("R6 done pulse", 32'(done), 32'd1);
        chk("R6 busy low at done", 32'(busy), 32'd0);
        chk("R5 valid ends", 32'(pix_valid), 32'd0);
        @(negedge clk);
        chk("R6 done one cycle", 32'(done), 32'd0);
        chk("R8 src holds", 32'(src_addr), 32'(last_s));
        chk("R8 dst holds", 32'(dst_addr), 32'(last_d));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset valid", 32'(pix_valid), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset src", 32'(src_addr), 32'd0);
        chk("R1 reset dst", 32'(dst_addr), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset valid", 32'(pix_valid), 32'd0);

        // R4 reference lines: stretch 2 over 4, squash 17 into 4
        run_line(16'h0100, 16'h0200, 4, 0, 2, 1'b0);
        chk("R4 stretch offset 3", 32'(model_src(16'h0100, 4, 0, 2, 3)), 32'h0101);
        run_line(16'h0000, 16'h1000, 4, 5, 2, 1'b0);
        chk("R4 squash offset 2", 32'(model_src(16'h0000, 4, 5, 2, 2)), 32'd11);
        chk("R4 squash offset 3", 32'(model_src(16'h0000, 4, 5, 2, 3)), 32'd16);
        // R8 single pixel
        run_line(16'h1234, 16'h5678, 1, 7, 1, 1'b0);
        // R9 wrap, R7 start while busy
        run_line(16'hFFFE, 16'hFFFD, 12, 3, 5, 1'b1);
        run_line(16'hFF00, 16'hFFF0, 1024, 0, 1024, 1'b0);
        run_line(16'h8000, 16'hFC00, 1024, 2, 1, 1'b1);

        for (int t = 0; t < 150; t++) begin
            int cnt = (t % 10 == 0) ? int'($urandom_range(65, 300)) : int'($urandom_range(1, 64));
            int r   = int'($urandom_range(1, cnt));
            int n   = int'($urandom_range(0, 20));
            run_line(16'($urandom), 16'($urandom), cnt, n, r, bit'($urandom_range(0, 1)));
            if (t % 7 == 0) @(negedge clk);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #700000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule